// File: doc/BRIEF.md
# Flash Write-Status Read Generator

This block forms the byte returned on a host read of a byte-wide parallel NOR flash, including reads made while an internal program or erase is running. While the array is idle, each read returns the array byte unchanged. While an operation is in progress, the array is not consulted. Each read instead returns a status byte:

- the top bit carries a completion poll,
- the next bit carries a toggle that changes on every read,
- the low bits carry a fill pattern that depends on the operation.

The command decoder drives `op_start` for one cycle when an internal operation is launched. This happens after the last write strobe of a command: the fourth for a program, the sixth for an erase. On that cycle it also supplies the operation kind and, for a program, the byte being written. The operation timer holds `busy` high until the operation completes. The host read logic sends a one-cycle `rd_stb` for every read. The result appears on the registered `rd_data` one cycle later, qualified by `rd_valid`.

Top module: `wstat_readout`

## Requirements
- R1: After synchronous reset, `rd_data` is 0, `rd_valid` is 0, and the toggle phase is set so that the first busy read returns 1 in bit 6.
- R2: While busy with a program (`op_kind`=0), bit 7 of a read is the inverse of bit 7 of the latched program byte.
- R3: While busy with an erase (`op_kind`=1), bit 7 of a read is 0.
- R4: While busy, bit 6 is 1 on the first read after `op_start` and then alternates 0, 1, 0, … on each following read.
- R5: While busy, bits 5..0 equal the low six bits of the latched program byte for a program, and 6'b111111 for an erase.
- R6: While `busy` is low, a read returns `arr_data` unchanged in all eight bits. This includes bits 7 and 6, so the read shows true data after completion.
- R7: Each `op_start` re-arms the toggle phase so that the next busy read returns 1 in bit 6, whatever the phase left by the previous operation.
- R8: The toggle phase and `rd_data` change only on a cycle with `rd_stb` (or, for the phase, `op_start`). Idle clock cycles between reads do not advance the toggle.
- R9: While busy, `arr_data` has no effect on the returned byte.
- R10: `rd_valid` is high for exactly the one cycle after each `rd_stb`, and `rd_data` is updated on that same edge.
- R11: `op_kind` and `prog_byte` are sampled only on `op_start`. Later changes have no effect on status reads of the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse: an internal operation begins |
| op_kind | input | 1 | 0 = program, 1 = erase; sampled on `op_start` |
| prog_byte | input | DW | Byte being programmed; sampled on `op_start` |
| busy | input | 1 | High while the internal operation runs |
| rd_stb | input | 1 | One-cycle read request |
| arr_data | input | DW | Array data for the addressed location |
| rd_data | output | DW | Registered byte returned to the host |
| rd_valid | output | 1 | High the cycle after a read request |

## Verification
The bench checks that the toggle restarts at 1 on a second operation that follows one which ended after an odd number of reads. A design that only resets the phase at power-up would return 0 there. It also inserts idle cycles between busy reads, to catch a toggle that runs on the clock rather than on the strobe. It changes `prog_byte` and `arr_data` while busy, so that a design that fails to latch the program byte, or that leaks array bits into the status byte, returns wrong bits. Finally, it reads after `busy` falls, with array bytes whose bits 7 and 6 disagree with the last status. A design that keeps substituting status bits once the operation has finished fails that check.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;
endpackage

// File: rtl/wstat_op_latch.sv
module wstat_op_latch
  import wstat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start,
  input  logic          op_kind,
  input  logic [DW-1:0] prog_byte,
  output op_kind_e      kind_q,
  output logic [DW-1:0] byte_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= OP_PROGRAM;
      byte_q <= '0;
    end else if (op_start) begin
      kind_q <= op_kind_e'(op_kind);
      byte_q <= prog_byte;
    end
  end

  p_latch_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !op_start |=> ($stable(byte_q) && $stable(kind_q)));
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle (
  input  logic clk,
  input  logic rst,
  input  logic op_start,
  input  logic busy,
  input  logic rd_stb,
  output logic phase
);
  // phase = value bit 6 takes on the next busy read
  always_ff @(posedge clk) begin
    if (rst)                 phase <= 1'b1;
    else if (op_start)       phase <= 1'b1;
    else if (rd_stb && busy) phase <= ~phase;
  end

  p_phase_rearm_r7: assert property (@(posedge clk) disable iff (rst)
    op_start |=> phase);
  p_phase_still_r8: assert property (@(posedge clk) disable iff (rst)
    (!op_start && !rd_stb) |=> $stable(phase));
endmodule

// File: rtl/wstat_outreg.sv
module wstat_outreg
  import wstat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          rd_stb,
  input  logic          phase,
  input  op_kind_e      kind_q,
  input  logic [DW-1:0] byte_q,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;
  localparam int LOW_W    = DW - 2;

  logic [DW-1:0] status;

  always_comb begin
    status = '0;
    if (kind_q == OP_ERASE) begin
      status[POLL_BIT]    = 1'b0;
      status[LOW_W-1:0]   = '1;
    end else begin
      status[POLL_BIT]    = ~byte_q[POLL_BIT];
      status[LOW_W-1:0]   = byte_q[LOW_W-1:0];
    end
    status[TOG_BIT] = phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= busy ? status : arr_data;
    end
  end

  p_valid_lat_r10: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_valid);
  p_valid_drop_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rd_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));
  p_erase_poll_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && busy && kind_q == OP_ERASE) |=> !rd_data[POLL_BIT]);
  p_idle_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !busy) |=> rd_data == $past(arr_data));
endmodule

// File: rtl/wstat_readout.sv
module wstat_readout
  import wstat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start,
  input  logic          op_kind,
  input  logic [DW-1:0] prog_byte,
  input  logic          busy,
  input  logic          rd_stb,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  op_kind_e      kind_q;
  logic [DW-1:0] byte_q;
  logic          phase;

  wstat_op_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .prog_byte(prog_byte), .kind_q(kind_q), .byte_q(byte_q)
  );

  wstat_toggle u_tog (
    .clk(clk), .rst(rst), .op_start(op_start), .busy(busy),
    .rd_stb(rd_stb), .phase(phase)
  );

  wstat_outreg #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .busy(busy), .rd_stb(rd_stb), .phase(phase),
    .kind_q(kind_q), .byte_q(byte_q), .arr_data(arr_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/sim_wstat_readout.sv
module sim_wstat_readout;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_start = 1'b0;
  logic       op_kind = 1'b0;
  logic [7:0] prog_byte = '0;
  logic       busy = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] arr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wstat_readout #(.DW(8)) u0 (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .prog_byte(prog_byte), .busy(busy), .rd_stb(rd_stb),
    .arr_data(arr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one read: strobe for one cycle, sample after the registering edge
  task automatic do_read(input logic [7:0] arr, output logic [7:0] got, output logic vld);
    @(negedge clk); rd_stb = 1'b1; arr_data = arr;
    @(negedge clk); rd_stb = 1'b0;
    got = rd_data; vld = rd_valid;
  endtask

  task automatic start_op(input logic kind, input logic [7:0] pb);
    @(negedge clk); op_start = 1'b1; op_kind = kind; prog_byte = pb; busy = 1'b1;
    @(negedge clk); op_start = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
  endtask

  task automatic t_program;
    logic [7:0] g; logic v;
    start_op(1'b0, 8'hA5);
    do_read(8'h00, g, v);
    check("R2/R4/R5 first prog read", g, {1'b0, 1'b1, 6'h25});
    check("R10 valid", {7'd0, v}, 8'h01);
    @(negedge clk);
    check("R10 valid drop", {7'd0, rd_valid}, 8'h00);
    check("R8 hold", rd_data, {1'b0, 1'b1, 6'h25});
    prog_byte = 8'h3C;
    do_read(8'hFF, g, v);
    check("R4/R9/R11 second prog read", g, {1'b0, 1'b0, 6'h25});
    repeat (5) @(negedge clk);
    do_read(8'h12, g, v);
    check("R8 no advance on idle cycles", g, {1'b0, 1'b1, 6'h25});
    busy = 1'b0;
    do_read(8'hA5, g, v);
    check("R6 true data after program", g, 8'hA5);
    do_read(8'h81, g, v);
    check("R6 idle passthrough", g, 8'h81);
  endtask

  task automatic t_program_low7;
    logic [7:0] g; logic v;
    start_op(1'b0, 8'h4A);
    do_read(8'hC0, g, v);
    check("R2 inverse of bit7=0", g, {1'b1, 1'b1, 6'h0A});
    busy = 1'b0;
    do_read(8'h4A, g, v);
    check("R6 after complete", g, 8'h4A);
  endtask

  task automatic t_erase_rearm;
    logic [7:0] g; logic v;
    start_op(1'b1, 8'h00);
    do_read(8'h00, g, v);
    check("R3/R5 erase read 1", g, 8'h7F);
    do_read(8'h55, g, v);
    check("R3/R4/R9 erase read 2", g, 8'h3F);
    do_read(8'h00, g, v);
    check("R4 erase read 3", g, 8'h7F);
    busy = 1'b0;
    do_read(8'hFF, g, v);
    check("R6 erased reads ones", g, 8'hFF);
    // previous op ended after odd count: phase now 0; new op must re-arm
    start_op(1'b0, 8'h80);
    op_kind = 1'b1;
    do_read(8'hFF, g, v);
    check("R7/R11 rearm on new op", g, {1'b0, 1'b1, 6'h00});
    busy = 1'b0;
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_program_low7();
    t_erase_rearm();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule